// File: doc/BRIEF.md
# Word-Serial Modular Subtractor

This block computes D = (A - B) mod N for wide operands that live outside it, in word-addressed synchronous memories. It never holds a whole operand. It walks the words from least to most significant. It reads A and B through one shared read address, reads N through a separate read address, and writes each result word through a write address, write strobe and data bus. A one-cycle start pulse launches an operation, and a ready flag tells the surrounding logic when the result memory holds the final value. Both inputs are expected to be already reduced below N.

The work takes two passes over the words. The first pass forms A - B with a borrow that ripples between words through a register. It writes those raw differences to the result memory and keeps the borrow out of the top word. The second pass reads A, B and N again and forms the difference once more. If the kept borrow is set, it also adds N with its own ripple carry. It then overwrites every result word with the final value. The environment polls ready and then reads the result memory back.

Top module: `modsub_word_serial`

## Requirements
- R1: After reset, and while no start pulse arrives, ready is 1 and d_wr_en is 0.
- R2: A start pulse sampled while ready is 1 launches an operation, and ready is 0 in the following cycle.
- R3: A start pulse sampled while ready is 0 has no effect. This includes the cycle of the last result write. The result, the busy length and the write count are unchanged, and the block stays idle afterwards.
- R4: With A >= B, the result memory holds A - B when ready returns.
- R5: With A < B, the result memory holds (A - B + N) mod 2^(32*NUM_WORDS) when ready returns.
- R6: With A = B, every result word is 0.
- R7: Word address 0 holds the least significant word, for the operands and for the result. Read data is taken one cycle after its address was presented.
- R8: Each pass writes the addresses 0, 1, ..., NUM_WORDS-1 in consecutive cycles, so an operation makes exactly 2*NUM_WORDS writes.
- R9: Ready returns to 1 exactly 2*NUM_WORDS+2 cycles after the accepted start, which is right after the last result write.
- R10: d_wr_en is never 1 while ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that launches an operation |
| ready | output | 1 | 1 when idle and the result is complete |
| ab_rd_addr | output | ADDR_W | Word address for the A and B memories |
| n_rd_addr | output | ADDR_W | Word address for the N memory |
| a_rd_data | input | WORD_W | A word, one cycle after its address |
| b_rd_data | input | WORD_W | B word, one cycle after its address |
| n_rd_data | input | WORD_W | N word, one cycle after its address |
| d_wr_addr | output | ADDR_W | Result word address |
| d_wr_en | output | 1 | Result write strobe |
| d_wr_data | output | WORD_W | Result word |

## Verification
Two events can land in the same cycle. The final result word of the second pass is written, and a new start pulse is sampled while the block is still busy. The bench raises start in exactly that write cycle and lowers it as ready comes back. It then checks that the result is still correct, that the busy length and the write count did not change, and that ready stays high with no further writes. Inside each word, the borrow of the subtraction and the carry of the add-back also resolve together. Operand pairs that force long borrow chains, such as zero minus N-1, exercise that path.

// File: rtl/modsub_pkg.sv
package modsub_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_DIFF = 2'd1,
    PH_FIX  = 2'd2
  } phase_t;
endpackage

// File: rtl/modsub_seq.sv
module modsub_seq
  import modsub_pkg::*;
#(
  parameter int NUM_WORDS = 8,
  parameter int ADDR_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output phase_t            phase,
  output logic              ready,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_vld,
  output logic [ADDR_W-1:0] wr_idx,
  output logic              accept,
  output logic              pass_done,
  output logic              op_done
);
  localparam int CNT_W = ADDR_W + 1;
  localparam logic [CNT_W-1:0]  CNT_END  = CNT_W'(NUM_WORDS);
  localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(NUM_WORDS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             issue;
  logic             last_wr;

  assign issue     = (phase != PH_IDLE) && (cnt_q < CNT_END);
  assign last_wr   = wr_vld && (wr_idx == LAST_IDX);
  assign accept    = (phase == PH_IDLE) && start;
  assign pass_done = last_wr && (phase == PH_DIFF);
  assign op_done   = last_wr && (phase == PH_FIX);
  assign rd_addr   = issue ? cnt_q[ADDR_W-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      cnt_q  <= '0;
      wr_vld <= 1'b0;
      wr_idx <= '0;
      ready  <= 1'b1;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          wr_vld <= 1'b0;
          if (start) begin
            phase <= PH_DIFF;
            cnt_q <= '0;
            ready <= 1'b0;
          end
        end
        default: begin
          wr_vld <= issue;
          if (issue) begin
            wr_idx <= cnt_q[ADDR_W-1:0];
            cnt_q  <= cnt_q + CNT_W'(1);
          end
          if (pass_done) begin
            phase <= PH_FIX;
            cnt_q <= '0;
          end else if (op_done) begin
            phase <= PH_IDLE;
            ready <= 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/modsub_datapath.sv
module modsub_datapath
  import modsub_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_t            phase,
  input  logic              wr_vld,
  input  logic              accept,
  input  logic              pass_done,
  input  logic [WORD_W-1:0] a_word,
  input  logic [WORD_W-1:0] b_word,
  input  logic [WORD_W-1:0] n_word,
  output logic [WORD_W-1:0] res_word,
  output logic              borrow_out,
  output logic              fix_active
);
  // Word subtract with borrow in; returns {borrow_out, difference}.
  function automatic logic [WORD_W:0] sub_word(input logic [WORD_W-1:0] x,
                                                input logic [WORD_W-1:0] y,
                                                input logic bin);
    logic [WORD_W:0] t;
    t = {1'b0, x} - {1'b0, y} - {{WORD_W{1'b0}}, bin};
    return t;
  endfunction

  // Word add with carry in; returns {carry_out, sum}.
  function automatic logic [WORD_W:0] add_word(input logic [WORD_W-1:0] x,
                                                input logic [WORD_W-1:0] y,
                                                input logic cin);
    return {1'b0, x} + {1'b0, y} + {{WORD_W{1'b0}}, cin};
  endfunction

  logic              borrow_q, carry_q, fix_q;
  logic [WORD_W:0]   sub_r, add_r;
  logic [WORD_W-1:0] addend;

  assign sub_r      = sub_word(a_word, b_word, borrow_q);
  assign borrow_out = sub_r[WORD_W];
  assign addend     = fix_q ? n_word : '0;
  assign add_r      = add_word(sub_r[WORD_W-1:0], addend, carry_q);
  assign fix_active = fix_q;
  assign res_word   = (phase == PH_FIX) ? add_r[WORD_W-1:0] : sub_r[WORD_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      borrow_q <= 1'b0;
      carry_q  <= 1'b0;
      fix_q    <= 1'b0;
    end else if (accept) begin
      borrow_q <= 1'b0;
      carry_q  <= 1'b0;
      fix_q    <= 1'b0;
    end else if (pass_done) begin
      borrow_q <= 1'b0;
      carry_q  <= 1'b0;
      fix_q    <= sub_r[WORD_W];
    end else if (wr_vld) begin
      borrow_q <= sub_r[WORD_W];
      carry_q  <= add_r[WORD_W];
    end
  end
endmodule

// File: rtl/modsub_word_serial.sv
module modsub_word_serial
  import modsub_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 8,
  parameter int ADDR_W    = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              ready,
  output logic [ADDR_W-1:0] ab_rd_addr,
  output logic [ADDR_W-1:0] n_rd_addr,
  input  logic [WORD_W-1:0] a_rd_data,
  input  logic [WORD_W-1:0] b_rd_data,
  input  logic [WORD_W-1:0] n_rd_data,
  output logic [ADDR_W-1:0] d_wr_addr,
  output logic              d_wr_en,
  output logic [WORD_W-1:0] d_wr_data
);
  phase_t            phase;
  logic [ADDR_W-1:0] rd_addr;
  logic              wr_vld;
  logic [ADDR_W-1:0] wr_idx;
  logic              accept, pass_done, op_done;
  logic              borrow_out, fix_active;

  modsub_seq #(
    .NUM_WORDS(NUM_WORDS),
    .ADDR_W   (ADDR_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .phase    (phase),
    .ready    (ready),
    .rd_addr  (rd_addr),
    .wr_vld   (wr_vld),
    .wr_idx   (wr_idx),
    .accept   (accept),
    .pass_done(pass_done),
    .op_done  (op_done)
  );

  modsub_datapath #(
    .WORD_W(WORD_W)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase     (phase),
    .wr_vld    (wr_vld),
    .accept    (accept),
    .pass_done (pass_done),
    .a_word    (a_rd_data),
    .b_word    (b_rd_data),
    .n_word    (n_rd_data),
    .res_word  (d_wr_data),
    .borrow_out(borrow_out),
    .fix_active(fix_active)
  );

  assign ab_rd_addr = rd_addr;
  assign n_rd_addr  = rd_addr;
  assign d_wr_addr  = wr_idx;
  assign d_wr_en    = wr_vld;
endmodule

// File: rtl/modsub_word_serial_chk.sv
module modsub_word_serial_chk #(
  parameter int NUM_WORDS = 8,
  parameter int ADDR_W    = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              ready,
  input logic              d_wr_en,
  input logic [ADDR_W-1:0] d_wr_addr
);
  localparam int CW = $clog2(2 * NUM_WORDS + 3) + 1;

  logic [CW-1:0] wr_cnt, busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_cnt   <= '0;
      busy_cnt <= '0;
    end else if (ready && start) begin
      wr_cnt   <= '0;
      busy_cnt <= '0;
    end else begin
      if (d_wr_en) wr_cnt <= wr_cnt + CW'(1);
      if (!ready)  busy_cnt <= busy_cnt + CW'(1);
    end
  end

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ready && !start |=> ready); // R1
  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    ready && start |=> !ready); // R2
  AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !d_wr_en); // R10
  AST_FIRST_WRITE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    d_wr_en && !$past(d_wr_en) |-> d_wr_addr == '0); // R8
  AST_WRITE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    d_wr_en && $past(d_wr_en) |-> d_wr_addr == ADDR_W'($past(d_wr_addr) + 1'b1)); // R8
  AST_WRITE_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> wr_cnt == CW'(2 * NUM_WORDS)); // R8
  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> busy_cnt == CW'(2 * NUM_WORDS + 2)); // R9
endmodule

bind modsub_word_serial modsub_word_serial_chk #(
  .NUM_WORDS(NUM_WORDS),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .ready    (ready),
  .d_wr_en  (d_wr_en),
  .d_wr_addr(d_wr_addr)
);

// File: tb/modsub_word_serial_test.sv
`timescale 1ns/1ps
module modsub_word_serial_test;
  localparam int WORD_W = 32;
  localparam int NUM    = 8;
  localparam int AW     = 3;
  localparam int OPW    = WORD_W * NUM;
  localparam logic [OPW-1:0] PRIME =
    256'hffffffff00000001000000000000000000000000ffffffffffffffffffffffff;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic ready, d_wr_en;
  logic [AW-1:0] ab_rd_addr, n_rd_addr, d_wr_addr;
  logic [WORD_W-1:0] a_q, b_q, n_q, d_wr_data;

  always #2.5 clk = ~clk;

  modsub_word_serial #(.WORD_W(WORD_W), .NUM_WORDS(NUM)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .ready(ready),
    .ab_rd_addr(ab_rd_addr), .n_rd_addr(n_rd_addr),
    .a_rd_data(a_q), .b_rd_data(b_q), .n_rd_data(n_q),
    .d_wr_addr(d_wr_addr), .d_wr_en(d_wr_en), .d_wr_data(d_wr_data)
  );

  logic [WORD_W-1:0] mem_a [NUM];
  logic [WORD_W-1:0] mem_b [NUM];
  logic [WORD_W-1:0] mem_n [NUM];
  logic [WORD_W-1:0] mem_d [NUM];

  int n_checks = 0;
  int n_fail   = 0;
  int wr_total = 0;
  int ord_err  = 0;
  int exp_idx  = 0;

  // Bench-side synchronous memories and write monitor.
  always @(posedge clk) begin
    a_q <= mem_a[ab_rd_addr];
    b_q <= mem_b[ab_rd_addr];
    n_q <= mem_n[n_rd_addr];
    if (d_wr_en) begin
      mem_d[d_wr_addr] <= d_wr_data;
      if (int'(d_wr_addr) != exp_idx) ord_err <= ord_err + 1;
      exp_idx  <= (exp_idx + 1) % NUM;
      wr_total <= wr_total + 1;
    end
  end

  function automatic logic [OPW-1:0] ref_modsub(input logic [OPW-1:0] a,
                                                input logic [OPW-1:0] b,
                                                input logic [OPW-1:0] n);
    logic [OPW:0] t;
    if (a < b) t = {1'b0, a} + {1'b0, n} - {1'b0, b};
    else       t = {1'b0, a} - {1'b0, b};
    return t[OPW-1:0];
  endfunction

  function automatic logic [OPW-1:0] rand_below(input logic [OPW-1:0] n);
    logic [OPW-1:0] v;
    for (int i = 0; i < NUM; i++) v[i*WORD_W +: WORD_W] = $urandom;
    if (v >= n) v = v - n;
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input logic [OPW-1:0] act,
                       input logic [OPW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // pulse_at: busy-cycle index at which an extra start is raised (-1 = none)
  task automatic run_op(input logic [OPW-1:0] a, input logic [OPW-1:0] b,
                        input logic [OPW-1:0] n, input int pulse_at, input string tag);
    logic [OPW-1:0] exp_d, got_d;
    int cyc, wr0, ord0;
    for (int i = 0; i < NUM; i++) begin
      mem_a[i] = a[i*WORD_W +: WORD_W];   // R7 address 0 = least significant
      mem_b[i] = b[i*WORD_W +: WORD_W];
      mem_n[i] = n[i*WORD_W +: WORD_W];
    end
    exp_d = ref_modsub(a, b, n);
    wr0 = wr_total; ord0 = ord_err;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(ready == 1'b0, "R2 ready low after accepted start", OPW'(ready), '0);
    cyc = 0;
    while (!ready && cyc < 100) begin
      @(negedge clk);
      cyc++;
      start = (cyc == pulse_at);
    end
    start = 1'b0;
    check(cyc == 2*NUM + 2, "R9 busy length", OPW'(cyc), OPW'(2*NUM + 2));
    for (int i = 0; i < NUM; i++) got_d[i*WORD_W +: WORD_W] = mem_d[i];
    check(got_d == exp_d, {"R7 result ", tag}, got_d, exp_d);
    check((wr_total - wr0) == 2*NUM && ord_err == ord0, "R8 write count and order",
          OPW'(wr_total - wr0), OPW'(2*NUM));
  endtask

  initial begin
    logic [OPW-1:0] x, y;
    int wr_snap;
    void'($urandom(32'd90210));
    for (int i = 0; i < NUM; i++) begin
      mem_a[i] = '0; mem_b[i] = '0; mem_n[i] = '0; mem_d[i] = '0;
    end
    repeat (3) @(negedge clk);
    check(ready == 1'b1 && d_wr_en == 1'b0, "R1 reset state", OPW'({ready, d_wr_en}), OPW'(2'b10));
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(ready == 1'b1 && d_wr_en == 1'b0, "R1 idle after reset", OPW'({ready, d_wr_en}), OPW'(2'b10));

    // R4 A >= B
    run_op(256'h5, 256'h3, PRIME, -1, "R4 small A>B");
    run_op(PRIME - 1, '0, PRIME, -1, "R4 max minus zero");
    // R5 A < B, long borrow chains through the add-back
    run_op(256'h3, 256'h5, PRIME, -1, "R5 small A<B");
    run_op('0, PRIME - 1, PRIME, -1, "R5 zero minus max");
    // R6 equal operands
    x = rand_below(PRIME);
    run_op(x, x, PRIME, -1, "R6 A equals B");
    for (int i = 0; i < NUM; i++)
      check(mem_d[i] == '0, "R6 zero word", OPW'(mem_d[i]), '0);
    // R3 start while busy, mid-operation
    x = rand_below(PRIME); y = rand_below(PRIME);
    run_op(x, y, PRIME, 5, "R3 start mid-operation");
    // R3 start in the cycle of the last result write
    x = rand_below(PRIME); y = rand_below(PRIME);
    run_op(y, x, PRIME, 2*NUM + 1, "R3 start at final write");
    wr_snap = wr_total;
    repeat (4) @(negedge clk);
    check(ready == 1'b1, "R3 stays idle after collided start", OPW'(ready), OPW'(1));
    check(wr_total == wr_snap, "R10 no writes while idle", OPW'(wr_total), OPW'(wr_snap));

    // Random pairs, both orderings
    for (int k = 0; k < 20; k++) begin
      x = rand_below(PRIME); y = rand_below(PRIME);
      run_op(x, y, PRIME, -1, (x >= y) ? "R4 random" : "R5 random");
      run_op(y, x, PRIME, -1, (y >= x) ? "R4 random swap" : "R5 random swap");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule